// File: doc/BRIEF.md
# Chunked Memory CRC Integrity Checker

This block guards a memory region across a power-down. Before the power-down, a store pass walks the region in fixed-size chunks. It computes a CRC-32 over each chunk and writes one 32-bit signature per chunk into a signature RAM. After the wake-up, a verify pass walks the same region again and recomputes each chunk CRC. It reads back the signature held for that chunk and reports every chunk whose two values differ.

Some chunks may legitimately change between the passes. This happens when a chunk overlaps the area that holds the signatures, or overlaps a fixed 128-byte register save area. The verify pass skips any chunk that touches either window. A skipped chunk still uses up its signature slot, so every chunk after it is still compared with its own stored value.

The block has a one-cycle-latency byte read port into the memory and a one-cycle-latency word port into the signature RAM. Its configuration inputs must be held steady during a pass. A one-cycle report strobe carries each mismatch. At the end of every pass the block raises a done pulse and presents the number of mismatches found.

Top module: `ccrc_checker`

## Requirements
- R1: The chunk size in bytes is `cfg_chunk_kib` × 1024. Chunk k starts at `cfg_start` + k × chunk size.
- R2: The region runs from `cfg_start` up to, but not including, `cfg_end`. It holds ceil((`cfg_end` − `cfg_start`) / chunk size) chunks, and chunk k uses signature slot k (`sig_addr` = k).
- R3: A chunk CRC is the reflected CRC-32 (polynomial 0xEDB88320, shifted LSB-first). The register is preset to 0xFFFFFFFF, and no final XOR is applied. Bytes are fed in ascending address order.
- R4: Each chunk covers min(chunk size, `cfg_end` − chunk start) bytes, so the last chunk may be short. No read is issued at or beyond `cfg_end`.
- R5: A store pass (`mode` = 0) writes the CRC of every chunk to its slot, including chunks that overlap a window. It raises no mismatch report.
- R6: A verify pass (`mode` = 1) writes no signatures. When a recomputed CRC differs from the stored one, it pulses `mis_valid` for one cycle with the chunk start address, the recomputed CRC and the stored CRC. It then carries on with the next chunk.
- R7: In a verify pass, a chunk that overlaps the signature window (`cfg_win0_base`, length `cfg_win0_len` bytes) is skipped and never reported.
- R8: In a verify pass, a chunk that overlaps the 128-byte save window starting at `cfg_win1_base` is skipped and never reported.
- R9: The overlap test is inclusive. A window with end = base + length touches a chunk with end = start + chunk length, unless the window end is below the chunk start or the window base is above the chunk end.
- R10: A skipped chunk still advances the signature slot, so later chunks are compared with their own slots.
- R11: `done` pulses for exactly one cycle at the end of each pass. `err_count` is cleared when a pass starts and then holds that pass's number of mismatches. An empty region (`cfg_end` ≤ `cfg_start`) finishes with no reads and no writes.
- R12: After reset, `busy`, `done` and `mis_valid` are 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a pass when idle |
| mode | input | 1 | 0 = store pass, 1 = verify pass |
| cfg_chunk_kib | input | KIB_W | Chunk size in KiB (at least 1) |
| cfg_start | input | ADDR_W | First byte address of the region |
| cfg_end | input | ADDR_W | Exclusive end address of the region |
| cfg_win0_base | input | ADDR_W | Signature window base |
| cfg_win0_len | input | ADDR_W | Signature window length in bytes |
| cfg_win1_base | input | ADDR_W | Base of the 128-byte save window |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Read byte, valid one cycle after `mem_rd` |
| sig_we | output | 1 | Signature write strobe |
| sig_re | output | 1 | Signature read strobe |
| sig_addr | output | SIG_AW | Signature slot index |
| sig_wdata | output | 32 | Signature to store |
| sig_rdata | input | 32 | Stored signature, valid one cycle after `sig_re` |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| err_count | output | SIG_AW+1 | Mismatches found in the last pass |
| mis_valid | output | 1 | Mismatch report strobe |
| mis_addr | output | ADDR_W | Start address of the mismatching chunk |
| mis_calc | output | 32 | Recomputed CRC |
| mis_stored | output | 32 | Stored CRC |

## Verification
The assertions rely on the environment holding the configuration inputs steady for the length of a pass and on `cfg_chunk_kib` being at least 1. They also rely on both RAM ports returning data exactly one cycle after a strobe. The bench only changes configuration while `busy` is low, always uses a non-zero chunk size, and models both RAMs as one-cycle synchronous reads. It also keeps the region within its 4 KiB memory model so that every address the block may read is backed by data.

// File: rtl/ccrc_pkg.sv
package ccrc_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;
    localparam int          SAVE_WIN_BYTES = 128;
    localparam int          NUM_WIN        = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STREAM,
        ST_FINAL,
        ST_CMP,
        ST_NEXT,
        ST_FIN
    } ccrc_state_e;

    typedef enum logic {
        MODE_STORE  = 1'b0,
        MODE_VERIFY = 1'b1
    } ccrc_mode_e;

    // one byte through the reflected CRC-32, low bit first
    function automatic logic [31:0] crc_byte_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ccrc_crc_engine.sv
module ccrc_crc_engine
    import ccrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= CRC_PRESET;
        end else if (en) begin
            crc_q <= crc_byte_step(crc_q, din);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/ccrc_overlap.sv
module ccrc_overlap #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] chunk_lo,
    input  logic [ADDR_W-1:0] chunk_len,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_len,
    output logic              hit
);
    logic [ADDR_W:0] chunk_hi;
    logic [ADDR_W:0] win_hi;

    always_comb begin
        chunk_hi = {1'b0, chunk_lo} + {1'b0, chunk_len};
        win_hi   = {1'b0, win_lo} + {1'b0, win_len};
        // inclusive: touching endpoints counts as overlap
        hit = !((win_hi < {1'b0, chunk_lo}) || ({1'b0, win_lo} > chunk_hi));
    end
endmodule

// File: rtl/ccrc_checker.sv
module ccrc_checker
    import ccrc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int KIB_W  = 6,
    parameter int SIG_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mode,
    input  logic [KIB_W-1:0]    cfg_chunk_kib,
    input  logic [ADDR_W-1:0]   cfg_start,
    input  logic [ADDR_W-1:0]   cfg_end,
    input  logic [ADDR_W-1:0]   cfg_win0_base,
    input  logic [ADDR_W-1:0]   cfg_win0_len,
    input  logic [ADDR_W-1:0]   cfg_win1_base,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [7:0]          mem_rdata,
    output logic                sig_we,
    output logic                sig_re,
    output logic [SIG_AW-1:0]   sig_addr,
    output logic [31:0]         sig_wdata,
    input  logic [31:0]         sig_rdata,
    output logic                busy,
    output logic                done,
    output logic [SIG_AW:0]     err_count,
    output logic                mis_valid,
    output logic [ADDR_W-1:0]   mis_addr,
    output logic [31:0]         mis_calc,
    output logic [31:0]         mis_stored
);
    localparam int CNT_W = SIG_AW + 1;

    ccrc_state_e       st_q;
    ccrc_mode_e        mode_q;
    logic [ADDR_W-1:0] cur_q, end_q, chunk_q, len_q, issued_q, got_q;
    logic [SIG_AW-1:0] idx_q;
    logic [CNT_W-1:0]  errs_q;
    logic              rv_q;

    logic [ADDR_W-1:0] remain, clen;
    logic [ADDR_W-1:0] wbase [NUM_WIN];
    logic [ADDR_W-1:0] wlen  [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    logic              skip;
    logic [31:0]       crc;

    assign wbase[0] = cfg_win0_base;
    assign wlen[0]  = cfg_win0_len;
    assign wbase[1] = cfg_win1_base;
    assign wlen[1]  = ADDR_W'(SAVE_WIN_BYTES);

    always_comb begin
        remain = end_q - cur_q;
        clen   = (remain < chunk_q) ? remain : chunk_q;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ccrc_overlap #(.ADDR_W(ADDR_W)) u_ov (
            .chunk_lo (cur_q),
            .chunk_len(clen),
            .win_lo   (wbase[w]),
            .win_len  (wlen[w]),
            .hit      (win_hit[w])
        );
    end

    assign skip = (mode_q == MODE_VERIFY) && (|win_hit);

    ccrc_crc_engine u_crc (
        .clk(clk),
        .rst(rst),
        .clr(st_q == ST_SETUP),
        .en (rv_q),
        .din(mem_rdata),
        .crc(crc)
    );

    assign mem_rd     = (st_q == ST_STREAM) && (issued_q != len_q);
    assign mem_addr   = cur_q + issued_q;
    assign sig_we     = (st_q == ST_FINAL) && (mode_q == MODE_STORE);
    assign sig_re     = (st_q == ST_FINAL) && (mode_q == MODE_VERIFY);
    assign sig_addr   = idx_q;
    assign sig_wdata  = crc;
    assign mis_valid  = (st_q == ST_CMP) && (sig_rdata != crc);
    assign mis_addr   = cur_q;
    assign mis_calc   = crc;
    assign mis_stored = sig_rdata;
    assign done       = (st_q == ST_FIN);
    assign busy       = (st_q != ST_IDLE);
    assign err_count  = errs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mode_q   <= MODE_STORE;
            cur_q    <= '0;
            end_q    <= '0;
            chunk_q  <= '0;
            len_q    <= '0;
            issued_q <= '0;
            got_q    <= '0;
            idx_q    <= '0;
            errs_q   <= '0;
            rv_q     <= 1'b0;
        end else begin
            rv_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= ccrc_mode_e'(mode);
                        cur_q   <= cfg_start;
                        end_q   <= cfg_end;
                        chunk_q <= ADDR_W'(cfg_chunk_kib) << 10;
                        idx_q   <= '0;
                        errs_q  <= '0;
                        st_q    <= (cfg_end > cfg_start) ? ST_SETUP : ST_FIN;
                    end
                end
                ST_SETUP: begin
                    len_q    <= clen;
                    issued_q <= '0;
                    got_q    <= '0;
                    st_q     <= skip ? ST_NEXT : ST_STREAM;
                end
                ST_STREAM: begin
                    if (mem_rd) issued_q <= issued_q + 1'b1;
                    rv_q <= mem_rd;
                    if (rv_q) begin
                        got_q <= got_q + 1'b1;
                        if (got_q == len_q - 1'b1) st_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    st_q <= (mode_q == MODE_VERIFY) ? ST_CMP : ST_NEXT;
                end
                ST_CMP: begin
                    if (mis_valid) errs_q <= errs_q + 1'b1;
                    st_q <= ST_NEXT;
                end
                ST_NEXT: begin
                    idx_q <= idx_q + 1'b1;
                    if (remain <= chunk_q) begin
                        st_q <= ST_FIN;
                    end else begin
                        cur_q <= cur_q + chunk_q;
                        st_q  <= ST_SETUP;
                    end
                end
                ST_FIN: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R5: a store pass never reports
    a_r5_store_silent: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == MODE_STORE) |-> !mis_valid);

    // R6: a verify pass never writes signatures
    a_r6_verify_no_write: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == MODE_VERIFY) |-> !sig_we);

    // R4: reads stay below the region end and inside one chunk
    a_r4_read_bounded: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr < end_q) && (issued_q < chunk_q));

    // R7: a skipped chunk issues no read
    a_r7_skip_no_read: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETUP && skip) |=> !mem_rd);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/ccrc_checker_test.sv
module ccrc_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 20;
    localparam int KIB_W  = 6;
    localparam int SIG_AW = 8;
    localparam int MEM_BYTES = 4096;
    localparam int NSIG = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [KIB_W-1:0]  cfg_chunk_kib = 6'd1;
    logic [ADDR_W-1:0] cfg_start = '0, cfg_end = '0;
    logic [ADDR_W-1:0] cfg_win0_base = 20'hF00, cfg_win0_len = 20'h10, cfg_win1_base = 20'hF80;
    logic mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rdata;
    logic sig_we, sig_re;
    logic [SIG_AW-1:0] sig_addr;
    logic [31:0] sig_wdata, sig_rdata;
    logic busy, done, mis_valid;
    logic [SIG_AW:0] err_count;
    logic [ADDR_W-1:0] mis_addr;
    logic [31:0] mis_calc, mis_stored;

    logic [7:0]  mem [MEM_BYTES];
    logic [31:0] sig [NSIG];

    int n_tests = 0;
    int n_fail = 0;
    int n_mis = 0;
    int n_wr = 0;
    logic [ADDR_W-1:0] m_addr [8];
    logic [31:0] m_calc [8];
    logic [31:0] m_stored [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccrc_checker #(.ADDR_W(ADDR_W), .KIB_W(KIB_W), .SIG_AW(SIG_AW)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .cfg_chunk_kib(cfg_chunk_kib), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_win0_base(cfg_win0_base), .cfg_win0_len(cfg_win0_len), .cfg_win1_base(cfg_win1_base),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .sig_we(sig_we), .sig_re(sig_re), .sig_addr(sig_addr), .sig_wdata(sig_wdata),
        .sig_rdata(sig_rdata), .busy(busy), .done(done), .err_count(err_count),
        .mis_valid(mis_valid), .mis_addr(mis_addr), .mis_calc(mis_calc), .mis_stored(mis_stored)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (sig_we) sig[sig_addr[3:0]] <= sig_wdata;
        sig_rdata <= sig[sig_addr[3:0]];
    end

    always @(negedge clk) begin
        if (!rst && mis_valid) begin
            if (n_mis < 8) begin
                m_addr[n_mis] = mis_addr;
                m_calc[n_mis] = mis_calc;
                m_stored[n_mis] = mis_stored;
            end
            n_mis++;
        end
        if (!rst && sig_we) n_wr++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int lo, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'd0, mem[lo + i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic run_pass(input bit m);
        n_mis = 0;
        n_wr = 0;
        @(negedge clk);
        mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done, "R11 done single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic set_region(input int s, input int e, input int kib);
        cfg_start = ADDR_W'(s);
        cfg_end = ADDR_W'(e);
        cfg_chunk_kib = KIB_W'(kib);
    endtask

    task automatic windows_far();
        cfg_win0_base = 20'hF00;
        cfg_win0_len = 20'h10;
        cfg_win1_base = 20'hF80;
    endtask

    logic [31:0] gold [3];

    task automatic t_reset();
        chk(!busy && !done && !mis_valid, "R12 reset outputs idle", {29'd0, busy, done, mis_valid}, 32'd0);
        chk(err_count == 0, "R12 reset err_count", 32'(err_count), 32'd0);
    endtask

    task automatic t_store();
        set_region(32'h100, 32'hC80, 1);
        cfg_win0_base = 20'h200; cfg_win0_len = 20'h10; cfg_win1_base = 20'h980;
        gold[0] = ref_crc(32'h100, 1024);
        gold[1] = ref_crc(32'h500, 1024);
        gold[2] = ref_crc(32'h900, 896);
        run_pass(1'b0);
        chk(sig[0] == gold[0], "R5 R3 store slot0 despite window", sig[0], gold[0]);
        chk(sig[1] == gold[1], "R1 R2 store slot1", sig[1], gold[1]);
        chk(sig[2] == gold[2], "R4 short last chunk slot2", sig[2], gold[2]);
        chk(sig[3] == 32'hDEADBEEF, "R2 slot3 untouched", sig[3], 32'hDEADBEEF);
        chk(n_wr == 3, "R2 three writes", 32'(n_wr), 32'd3);
        chk(n_mis == 0, "R5 no reports in store", 32'(n_mis), 32'd0);
    endtask

    task automatic t_verify_clean();
        windows_far();
        run_pass(1'b1);
        chk(n_mis == 0 && err_count == 0, "R6 clean verify", 32'(err_count), 32'd0);
        chk(n_wr == 0, "R6 verify writes nothing", 32'(n_wr), 32'd0);
    endtask

    task automatic t_verify_corrupt();
        logic [31:0] bad;
        windows_far();
        mem[32'h600] ^= 8'hFF;
        bad = ref_crc(32'h500, 1024);
        run_pass(1'b1);
        chk(n_mis == 1 && err_count == 1, "R6 one mismatch", 32'(err_count), 32'd1);
        chk(m_addr[0] == 20'h500, "R6 mismatch address", 32'(m_addr[0]), 32'h500);
        chk(m_calc[0] == bad, "R6 recomputed crc", m_calc[0], bad);
        chk(m_stored[0] == gold[1], "R6 stored crc", m_stored[0], gold[1]);
    endtask

    task automatic t_boundary();
        cfg_win0_base = 20'h0; cfg_win0_len = 20'h4FF; cfg_win1_base = 20'hF80;
        run_pass(1'b1);
        chk(n_mis == 1 && m_addr[0] == 20'h500, "R9 window ending before chunk start not skipped",
            32'(n_mis), 32'd1);
        cfg_win0_len = 20'h500;
        run_pass(1'b1);
        chk(n_mis == 0 && err_count == 0, "R7 R9 window touching chunk start skips", 32'(err_count), 32'd0);
    endtask

    task automatic t_save_window();
        logic [31:0] bad2;
        windows_far();
        cfg_win1_base = 20'h600;
        mem[32'hA00] ^= 8'h5A;
        bad2 = ref_crc(32'h900, 896);
        run_pass(1'b1);
        chk(n_mis == 1 && err_count == 1, "R8 save window skips chunk1", 32'(err_count), 32'd1);
        chk(m_addr[0] == 20'h900, "R10 next chunk address", 32'(m_addr[0]), 32'h900);
        chk(m_stored[0] == gold[2] && m_calc[0] == bad2, "R10 slot alignment after skip", m_stored[0], gold[2]);
        mem[32'hA00] ^= 8'h5A;
        mem[32'h600] ^= 8'hFF;
        windows_far();
    endtask

    task automatic t_empty();
        set_region(32'h300, 32'h300, 1);
        run_pass(1'b0);
        chk(n_wr == 0 && err_count == 0, "R11 empty region", 32'(n_wr), 32'd0);
    endtask

    task automatic t_chunk2();
        logic [31:0] g0, g1;
        set_region(32'h100, 32'hC80, 2);
        g0 = ref_crc(32'h100, 2048);
        g1 = ref_crc(32'h900, 896);
        run_pass(1'b0);
        chk(sig[0] == g0 && n_wr == 2, "R1 two-KiB chunk slot0", sig[0], g0);
        chk(sig[1] == g1, "R4 two-KiB short tail", sig[1], g1);
        chk(sig[2] == gold[2], "R2 slot2 kept", sig[2], gold[2]);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        for (int i = 0; i < NSIG; i++) sig[i] = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store();
        t_verify_clean();
        t_verify_corrupt();
        t_boundary();
        t_save_window();
        t_empty();
        t_chunk2();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule